// File: doc/BRIEF.md
# Two-Input Interval Capture Timer

This block measures the time between a rising edge on one external input and a rising edge on a second external input. A free-running up counter advances once for each tick. The tick is the underflow strobe of an upstream prescaler and is not the system clock. Each of the two asynchronous inputs is first brought into the clock domain. A detected rising edge then freezes the current count into that input's own holding register.

Only the second input raises an interrupt. That input sets a one-cycle request pulse and a sticky status bit. Software can therefore arm the measurement, wait for that single interrupt, read both holding registers, and subtract them modulo 2^16 to get the interval in ticks. Software does nothing between the two edges.

A small register file gives software its controls. A control word holds the count enable and a self-clearing counter-clear command. The counter and both holding registers are read-only, and the status bit is cleared by writing 1 to it.

Top module: `dual_edge_capture_timer`

## Requirements
- R1: While enabled, the counter adds one on each clock edge at which `tick` is 1. It is CNT_W (16) bits wide and wraps from 65535 to 0.
- R2: While the enable bit is 0, the counter keeps its value whatever `tick` does. A write to the enable bit takes effect at the following edge.
- R3: A write to address 0 with bit 1 set clears the counter to 0. The clear wins over a tick in the same cycle. Bit 1 is not stored and always reads back 0.
- R4: A rising edge on `cap_a_in` is counted from the first clock edge that samples it high. At the third such edge, holding register A loads the count held before that edge, which is the pre-increment value if a tick coincides.
- R5: `cap_b_in` loads holding register B with the same timing and the same pre-increment rule as R4.
- R6: `irq` is high for exactly one cycle. It rises at the same edge at which holding register B loads. A capture on input A never drives `irq`.
- R7: The status bit (address 4, bit 0) is set together with `irq`. Writing 1 to bit 0 clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over the clear.
- R8: Holding register B minus holding register A, taken modulo 2^16, equals the number of counted ticks between the two captures, and this holds across a counter wrap.
- R9: After reset, every register reads 0, the counter is disabled and `irq` is 0.
- R10: The register map is: 0 = control (bit 0 enable, bit 1 clear), 1 = count, 2 = holding A, 3 = holding B, 4 = status. `reg_rdata` shows the value addressed at a clock edge, taken as it stood just before that edge.
- R11: An input held high, or a falling edge, causes no further capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe from the upstream prescaler |
| cap_a_in | input | 1 | Asynchronous start input |
| cap_b_in | input | 1 | Asynchronous stop input |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | One-cycle interrupt on stop capture |

## Verification
Interval sweeps run with the tick present on every cycle, on every second cycle and on every third cycle. Gaps between start and stop run from zero, where both inputs rise together, through twenty cycles. The every-cycle case proves that the difference equals the cycle gap exactly. The sparse-tick cases separate pre-increment capture from post-increment capture. A long run up to just below 65535, followed by a start and stop pair straddling the wrap, shows that the modulo difference survives rollover. Separate steps hold inputs high, toggle the enable, clear the counter while ticks arrive, and write 0 and then 1 to the status bit, which tells apart hold, clear priority and write-one-to-clear behaviour.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    RA_MODE  = 3'd0,
    RA_COUNT = 3'd1,
    RA_CAPA  = 3'd2,
    RA_CAPB  = 3'd3,
    RA_STAT  = 3'd4
  } reg_addr_e;
  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_CLR_BIT = 1;
  localparam int STAT_DONE_BIT = 0;
endpackage

// File: rtl/dct_edge_sync.sv
module dct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  // pipe[0..STAGES-1] synchroniser, pipe[STAGES] previous sample
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst)             count_o <= '0;
    else if (clr)        count_o <= '0;
    else if (en && tick) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/dct_hold_reg.sv
module dct_hold_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/dual_edge_capture_timer.sv
module dual_edge_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cap_a_in,
  input  logic              cap_b_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_in, rise;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  hold [NUM_IN];
  logic              en_q, stat_q;
  logic              mode_wr, stat_wr, clr_pulse, stat_clr;
  logic              edge_a, edge_b;
  logic [CNT_W-1:0]  cap_a, cap_b;

  assign raw_in = {cap_b_in, cap_a_in};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_chan
      dct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(raw_in[gi]), .rise_o(rise[gi])
      );
      dct_hold_reg #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst(rst), .load(rise[gi]), .din(count), .q(hold[gi])
      );
    end
  endgenerate

  assign edge_a = rise[0];
  assign edge_b = rise[1];
  assign cap_a  = hold[0];
  assign cap_b  = hold[1];

  assign mode_wr   = reg_wr && (reg_addr == RA_MODE);
  assign stat_wr   = reg_wr && (reg_addr == RA_STAT);
  assign clr_pulse = mode_wr && reg_wdata[MODE_CLR_BIT];
  assign stat_clr  = stat_wr && reg_wdata[STAT_DONE_BIT];

  dct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .clr(clr_pulse), .en(en_q), .tick(tick),
    .count_o(count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (mode_wr) en_q <= reg_wdata[MODE_EN_BIT];
      stat_q <= (stat_q && !stat_clr) || edge_b;
      irq    <= edge_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_MODE:  reg_rdata <= {{(CNT_W-1){1'b0}}, en_q};
        RA_COUNT: reg_rdata <= count;
        RA_CAPA:  reg_rdata <= cap_a;
        RA_CAPB:  reg_rdata <= cap_b;
        RA_STAT:  reg_rdata <= {{(CNT_W-1){1'b0}}, stat_q};
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             en_q,
  input logic             clr_pulse,
  input logic [CNT_W-1:0] count,
  input logic             edge_a,
  input logic             edge_b,
  input logic [CNT_W-1:0] cap_a,
  input logic [CNT_W-1:0] cap_b,
  input logic             irq,
  input logic             stat_q
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && tick && !clr_pulse) |=> count == CNT_W'($past(count) + 1'b1));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !clr_pulse) |=> $stable(count));
  // R3
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> count == '0);
  // R4
  capa_load_chk: assert property (@(posedge clk) disable iff (rst)
    edge_a |=> cap_a == $past(count));
  // R11
  capa_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_a |=> $stable(cap_a));
  // R5
  capb_load_chk: assert property (@(posedge clk) disable iff (rst)
    edge_b |=> cap_b == $past(count));
  // R11
  capb_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_b |=> $stable(cap_b));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    edge_b |=> irq);
  // R7
  stat_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> stat_q);
endmodule

bind dual_edge_capture_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .en_q(en_q), .clr_pulse(clr_pulse),
  .count(count), .edge_a(edge_a), .edge_b(edge_b), .cap_a(cap_a),
  .cap_b(cap_b), .irq(irq), .stat_q(stat_q)
);

// File: tb/dual_edge_capture_timer_bench.sv
module dual_edge_capture_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        cap_a_in = 1'b0, cap_b_in = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int errors = 0, checks = 0;
  int tick_per = 1, cyc = 0;
  logic [15:0] m_cnt = 0, m_a = 0, m_b = 0, m_rd = 0;
  logic        m_en = 0, m_st = 0, m_irq = 0;
  int pa = 0, pb = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_edge_capture_timer u_dual_edge_capture_timer (
    .clk(clk), .rst(rst), .tick(tick), .cap_a_in(cap_a_in), .cap_b_in(cap_b_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, back to negedge
  task automatic step();
    tick = (tick_per > 0) && (cyc % tick_per == 0);
    cyc++;
    @(posedge clk);
    case (reg_addr)
      3'd0: m_rd = {15'd0, m_en};
      3'd1: m_rd = m_cnt;
      3'd2: m_rd = m_a;
      3'd3: m_rd = m_b;
      3'd4: m_rd = {15'd0, m_st};
      default: m_rd = 0;
    endcase
    if (pa == 1) m_a = m_cnt;
    if (pb == 1) m_b = m_cnt;
    m_irq = (pb == 1);
    if (reg_wr && reg_addr == 0 && reg_wdata[1]) m_cnt = 0;
    else if (m_en && tick) m_cnt = m_cnt + 16'd1;
    if (reg_wr && reg_addr == 0) m_en = reg_wdata[0];
    if (reg_wr && reg_addr == 4 && reg_wdata[0]) m_st = 0;
    if (pb == 1) m_st = 1;
    if (pa > 0) pa--;
    if (pb > 0) pb--;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(irq == m_irq, "R6 irq", irq, m_irq);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
  endtask

  task automatic rd(input logic [2:0] a, input string req, output logic [15:0] v);
    reg_addr = a;
    step();
    v = reg_rdata;
    chk(reg_rdata == m_rd, req, reg_rdata, m_rd);
  endtask

  initial begin
    logic [15:0] v, va, vb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), "R9 reset value", v);
      chk(v == 0, "R9 zero", v, 0);
    end
    // R2 disabled with ticks
    tick_per = 1; steps(8);
    rd(3'd1, "R2 hold", v);
    chk(v == 0, "R2 count frozen", v, 0);
    // R1 enable and count, R10 mode readback (clear bit reads 0)
    wr(3'd0, 16'h0003);
    rd(3'd0, "R10 mode read", v);
    chk(v == 1, "R3 clear bit reads 0", v, 1);
    steps(10);
    rd(3'd1, "R1 count", v);
    // R3 clear wins over tick
    wr(3'd0, 16'h0003);
    rd(3'd1, "R3 cleared", v);
    chk(v == 0, "R3 count after clear", v, 0);
    // R2 disable holds
    wr(3'd0, 16'h0000); steps(6);
    rd(3'd1, "R2 held", va);
    steps(5);
    rd(3'd1, "R2 still held", vb);
    chk(va == vb, "R2 stable", vb, va);
    // sweep R4 R5 R8 over tick rates and gaps
    for (int p = 1; p <= 3; p++) begin
      for (int g = 0; g < 6; g++) begin
        int gap;
        gap = (g == 5) ? 20 : (g == 4 ? 7 : g);
        tick_per = p;
        wr(3'd0, 16'h0003);
        cap_a_in = 1'b1; pa = 3;
        if (gap == 0) begin cap_b_in = 1'b1; pb = 3; end
        else begin steps(gap); cap_b_in = 1'b1; pb = 3; end
        steps(5);
        rd(3'd2, "R4 capture A", va);
        rd(3'd3, "R5 capture B", vb);
        if (p == 1) chk(16'(vb - va) == 16'(gap), "R8 interval", 16'(vb - va), gap);
        else chk(16'(vb - va) == 16'(m_b - m_a), "R8 interval", 16'(vb - va), 16'(m_b - m_a));
        // R11 held high: no recapture
        steps(4);
        rd(3'd2, "R11 held A", v);
        chk(v == va, "R11 no recapture A", v, va);
        cap_a_in = 1'b0; cap_b_in = 1'b0;
        steps(4);
        rd(3'd3, "R11 fall B", v);
        chk(v == vb, "R11 falling edge ignored", v, vb);
      end
    end
    // R7 status W1C
    rd(3'd4, "R7 status set", v);
    chk(v == 1, "R7 status set", v, 1);
    wr(3'd4, 16'h0000);
    rd(3'd4, "R7 write 0 keeps", v);
    chk(v == 1, "R7 write 0 keeps", v, 1);
    wr(3'd4, 16'h0001);
    rd(3'd4, "R7 write 1 clears", v);
    chk(v == 0, "R7 cleared", v, 0);
    // R6 capture A alone: no irq (checked each step)
    cap_a_in = 1'b1; pa = 3; steps(6); cap_a_in = 1'b0; steps(4);
    rd(3'd4, "R6 A no status", v);
    chk(v == 0, "R6 A raises nothing", v, 0);
    // R1 R8 wrap
    tick_per = 1;
    wr(3'd0, 16'h0003);
    while (m_cnt != 16'd65525) step();
    cap_a_in = 1'b1; pa = 3; steps(12);
    cap_b_in = 1'b1; pb = 3; steps(5);
    rd(3'd2, "R1 wrap A", va);
    rd(3'd3, "R1 wrap B", vb);
    chk(vb < va, "R1 wrapped", vb, va);
    chk(16'(vb - va) == 16'd12, "R8 wrap interval", 16'(vb - va), 12);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", n, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule